// File: doc/BRIEF.md
# SONET STS-12 Byte Framer

This block takes a byte-wide STS-12 stream whose byte boundaries are arbitrary with respect to the line's octets. It looks for the transition from the last A1 framing byte to the first A2 framing byte at every one of the eight possible bit offsets. Once it finds that transition, it fixes the offset and presents a byte-aligned stream. A one-cycle frame pulse marks the first A1 byte of every frame. Downstream overhead and payload logic use this pulse as the 8 kHz frame reference.

Acquisition and loss of frame go through a small state machine. A detected pattern is confirmed over two following frames before the block reports in-frame. While in frame, each frame whose pattern is missing at the expected byte is counted as errored. Four errored frames in a row put the block back into the hunt. Two sticky alarm bits record errored frames and entries into out-of-frame, and software clears them by pulsing a clear input. A slower loss-of-frame indication integrates the out-of-frame state over 24 frame periods. It releases only after 24 frame periods spent in frame.

All counting advances only on bytes that carry valid data, so the input may have idle cycles. The byte clock is nominally 77.76 MHz, which gives 9720 byte times per frame. The frame length is a parameter.

Top module: `frm_byte_framer`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_fp, in_frame, err_alarm, oof_alarm and lof are all 0.
- R2: out_valid equals in_valid delayed by one clock in every state, in frame or not.
- R3: While hunting, the block detects the 16-bit sequence 0xF6 followed by 0x28 (first bit on the line is the MSB of each byte) at any of the eight bit offsets of the unaligned input, and it locks that offset.
- R4: in_frame rises only after the pattern appears at its expected position in the two frames that follow detection. It is still 0 after the detection frame plus one more frame.
- R5: While in frame, the output bytes follow the locked offset. The frame-pulse byte and the next NUM_A1-2 bytes read 0xF6, and the NUM_A1 bytes after the last A1 read 0x28.
- R6: out_fp is one cycle wide and coincides with the first A1 byte of each frame on the output. Consecutive pulses are exactly FRAME_LEN valid output bytes apart, and out_fp never asserts while in_frame is 0.
- R7: A frame whose A1-to-A2 boundary is missing at the locked position while in frame sets err_alarm. Fewer than four such frames in a row leave in_frame at 1, and one good frame restarts the count.
- R8: Four consecutive errored frames drop in_frame, set oof_alarm and restart the hunt. The hunt can then lock a different bit offset.
- R9: Both alarms are sticky. alarm_clr bit 0 clears err_alarm and bit 1 clears oof_alarm, each independently, and a new alarm event in the same cycle wins over the clear.
- R10: lof rises once the block has been out of frame for 24 consecutive frame periods. It falls once the block has been in frame for 24 consecutive frame periods.
- R11: Cycles with in_valid low neither advance the frame position nor shift the alignment window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | in_data carries a byte this cycle |
| in_data | input | 8 | Unaligned received byte, earliest bit in bit 7 |
| alarm_clr | input | 2 | Clear pulse: bit 0 errored-frame alarm, bit 1 out-of-frame alarm |
| out_valid | output | 1 | out_data carries a byte |
| out_data | output | 8 | Byte at the locked bit offset |
| out_fp | output | 1 | Frame pulse on the first A1 byte |
| in_frame | output | 1 | Block is in frame |
| err_alarm | output | 1 | Sticky errored-frame alarm |
| oof_alarm | output | 1 | Sticky out-of-frame entry alarm |
| lof | output | 1 | Loss of frame |

## Verification
The bench feeds a bit-slipped serial image of whole frames with random idle cycles, and it checks the bytes after every pulse. An off-by-one in the offset window or in the position counter would show up as a shifted pulse or as 0x28 bytes arriving late. Isolated and paired errored frames are sent to show that the miss counter survives three misses and resets on a good frame. A further run of four misses, followed by extra slipped bits, checks that the block drops frame and relocks at a new offset; a design that never reset the counter, or that froze the offset, would fail here. The LOF windows are sampled two frame periods either side of the 24-frame boundary in both directions. This catches an integrator that counts bytes or frames wrongly, or that does not restart.

// File: rtl/framer_pkg.sv
// Shared types for the byte framer.
package framer_pkg;

    // Framing state: hunting for the pattern, confirming a candidate, locked.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } frm_state_e;

endpackage

// File: rtl/frm_window.sv
// Alignment window.
// Keeps the last two valid input bytes. Together with the byte now arriving
// they form a 24-bit window. For each of the eight bit offsets it reports
// whether the 16 bits starting there equal {A1,A2}. It also produces the
// aligned byte at the selected offset. The aligned byte is taken from the
// newest 16 bits, so on a match it is the first A2 byte.
// Assumes the earliest received bit sits in bit 7 of each byte.
module frm_window #(
    parameter logic [7:0] A1_BYTE = 8'hF6,
    parameter logic [7:0] A2_BYTE = 8'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic [2:0] off,
    output logic [7:0] match_vec,
    output logic [7:0] aligned
);
    localparam int NOFF = 8;
    localparam logic [15:0] PATTERN = {A1_BYTE, A2_BYTE};

    logic [7:0]  hist1;
    logic [7:0]  hist0;
    logic [23:0] win;
    logic [15:0] pair;
    logic [7:0]  cand [NOFF];

    // Shift the byte history on every valid input byte only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1 <= '0;
            hist0 <= '0;
        end else if (in_valid) begin
            hist1 <= hist0;
            hist0 <= in_data;
        end
    end

    assign win  = {hist1, hist0, in_data};
    assign pair = {hist0, in_data};

    // One comparator and one candidate byte per bit offset.
    for (genvar k = 0; k < NOFF; k++) begin : g_off
        assign match_vec[k] = (win[23-k -: 16] == PATTERN);
        assign cand[k]      = pair[15-k -: 8];
    end

    // Select the candidate byte for the locked offset.
    assign aligned = cand[off];

endmodule

// File: rtl/frm_sync_fsm.sv
// Frame synchronisation state machine.
// Tracks the position of the aligned byte inside the frame, hunts for the
// A1/A2 boundary, confirms it over CONFIRM frames and counts errored frames
// while in frame. It also holds the two sticky alarms.
// Assumes NUM_A1 + 1 < FRAME_LEN and that step marks each valid byte.
module frm_sync_fsm
    import framer_pkg::*;
#(
    parameter int FRAME_LEN = 9720,
    parameter int NUM_A1    = 12,
    parameter int CONFIRM   = 2,
    parameter int ERR_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic [7:0] match_vec,
    input  logic [1:0] alarm_clr,
    output logic [2:0] off,
    output logic       in_frame,
    output logic       at_first_a1,
    output logic       frame_tick,
    output logic       err_alarm,
    output logic       oof_alarm
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int GC_W  = $clog2(CONFIRM + 1);
    localparam int BC_W  = $clog2(ERR_LIMIT + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] A2_IDX   = IDX_W'(NUM_A1);
    localparam logic [IDX_W-1:0] POST_A2  = IDX_W'(NUM_A1 + 1);

    frm_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_inc;
    logic [GC_W-1:0]  good_cnt;
    logic [BC_W-1:0]  bad_cnt;
    logic             found;
    logic [2:0]       found_k;
    logic             at_check;
    logic             good;
    logic             ev_err;
    logic             ev_oof;

    // Lowest offset with a match wins.
    always_comb begin
        found_k = '0;
        for (int k = 7; k >= 0; k--) begin
            if (match_vec[k]) found_k = 3'(k);
        end
        found = |match_vec;
    end

    // Position arithmetic and per-frame check point.
    always_comb begin
        idx_inc  = (idx == LAST_IDX) ? '0 : idx + 1'b1;
        at_check = (idx == A2_IDX);
        good     = match_vec[off];
    end

    // Alarm events: a miss while in frame, and the miss that ends the frame.
    always_comb begin
        ev_err = step && (state == ST_SYNC) && at_check && !good;
        ev_oof = ev_err && (bad_cnt == BC_W'(ERR_LIMIT - 1));
    end

    // State, frame position and acquisition/loss counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            idx      <= '0;
            off      <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
        end else if (step) begin
            idx <= idx_inc;
            unique case (state)
                ST_HUNT: begin
                    if (found) begin
                        off      <= found_k;
                        idx      <= POST_A2;
                        good_cnt <= '0;
                        state    <= ST_PRESYNC;
                    end
                end
                ST_PRESYNC: begin
                    if (at_check) begin
                        if (!good) begin
                            state <= ST_HUNT;
                        end else if (good_cnt == GC_W'(CONFIRM - 1)) begin
                            bad_cnt <= '0;
                            state   <= ST_SYNC;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (at_check) begin
                        if (good) begin
                            bad_cnt <= '0;
                        end else if (ev_oof) begin
                            state <= ST_HUNT;
                        end else begin
                            bad_cnt <= bad_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Sticky alarms: a clear pulse drops a bit, a new event sets it again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_alarm <= 1'b0;
            oof_alarm <= 1'b0;
        end else begin
            err_alarm <= ev_err | (err_alarm & ~alarm_clr[0]);
            oof_alarm <= ev_oof | (oof_alarm & ~alarm_clr[1]);
        end
    end

    assign in_frame    = (state == ST_SYNC);
    assign at_first_a1 = (idx == '0);
    assign frame_tick  = step && (idx == LAST_IDX);

endmodule

// File: rtl/frm_lof.sv
// Loss-of-frame integrator.
// Counts frame periods spent out of frame and in frame. lof rises after
// SET_FRAMES periods out of frame and falls after CLR_FRAMES in frame.
// Each count restarts when the frame state changes.
// Assumes tick pulses once per frame period.
module frm_lof #(
    parameter int SET_FRAMES = 24,
    parameter int CLR_FRAMES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic in_frame,
    output logic lof
);
    localparam int SW = $clog2(SET_FRAMES + 1);
    localparam int CW = $clog2(CLR_FRAMES + 1);

    logic [SW-1:0] oof_cnt;
    logic [CW-1:0] inf_cnt;

    // Integrate whichever state is current and restart the other count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oof_cnt <= '0;
            inf_cnt <= '0;
            lof     <= 1'b0;
        end else if (in_frame) begin
            oof_cnt <= '0;
            if (tick && inf_cnt != CW'(CLR_FRAMES)) begin
                inf_cnt <= inf_cnt + 1'b1;
                if (inf_cnt == CW'(CLR_FRAMES - 1)) lof <= 1'b0;
            end
        end else begin
            inf_cnt <= '0;
            if (tick && oof_cnt != SW'(SET_FRAMES)) begin
                oof_cnt <= oof_cnt + 1'b1;
                if (oof_cnt == SW'(SET_FRAMES - 1)) lof <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/frm_byte_framer.sv
// STS-12 byte framer, top level.
// Aligns an unaligned byte stream to the octets of the line by hunting for
// the A1/A2 boundary. It emits the aligned bytes with one clock of latency
// and a pulse on the first A1 byte while in frame, and it reports frame
// status and alarms. Assumes in_valid marks each received byte.
module frm_byte_framer #(
    parameter int         FRAME_LEN  = 9720,
    parameter int         NUM_A1     = 12,
    parameter logic [7:0] A1_BYTE    = 8'hF6,
    parameter logic [7:0] A2_BYTE    = 8'h28,
    parameter int         CONFIRM    = 2,
    parameter int         ERR_LIMIT  = 4,
    parameter int         LOF_SET    = 24,
    parameter int         LOF_CLR    = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic [1:0] alarm_clr,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_fp,
    output logic       in_frame,
    output logic       err_alarm,
    output logic       oof_alarm,
    output logic       lof
);
    logic [7:0] match_vec;
    logic [7:0] aligned;
    logic [2:0] off;
    logic       at_first_a1;
    logic       frame_tick;

    frm_window #(
        .A1_BYTE (A1_BYTE),
        .A2_BYTE (A2_BYTE)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .off       (off),
        .match_vec (match_vec),
        .aligned   (aligned)
    );

    frm_sync_fsm #(
        .FRAME_LEN (FRAME_LEN),
        .NUM_A1    (NUM_A1),
        .CONFIRM   (CONFIRM),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (in_valid),
        .match_vec   (match_vec),
        .alarm_clr   (alarm_clr),
        .off         (off),
        .in_frame    (in_frame),
        .at_first_a1 (at_first_a1),
        .frame_tick  (frame_tick),
        .err_alarm   (err_alarm),
        .oof_alarm   (oof_alarm)
    );

    frm_lof #(
        .SET_FRAMES (LOF_SET),
        .CLR_FRAMES (LOF_CLR)
    ) u_lof (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (frame_tick),
        .in_frame (in_frame),
        .lof      (lof)
    );

    // Output register: aligned byte, its valid flag and the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_fp    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_fp    <= in_valid && in_frame && at_first_a1;
            if (in_valid) out_data <= aligned;
        end
    end

endmodule

// File: rtl/frm_byte_framer_chk.sv
// Property checker for frm_byte_framer, attached with bind.
// Watches only the ports of the top module.
module frm_byte_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] alarm_clr,
    input logic       out_valid,
    input logic       out_fp,
    input logic       in_frame,
    input logic       err_alarm,
    input logic       oof_alarm,
    input logic       lof
);
    // R2: a valid input byte produces a valid output byte next cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: an idle input cycle produces an idle output cycle.
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6: the pulse only appears on a valid byte while in frame.
    a_r6_fp_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        out_fp |-> (in_frame && out_valid));

    // R6: the pulse is a single cycle wide.
    a_r6_fp_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_fp |=> !out_fp);

    // R9: err_alarm holds unless cleared.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_alarm && !alarm_clr[0]) |=> err_alarm);

    // R9: oof_alarm holds unless cleared.
    a_r9_oof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oof_alarm && !alarm_clr[1]) |=> oof_alarm);

    // R8: leaving frame always raises the out-of-frame alarm.
    a_r8_oof_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> oof_alarm);

    // R10: loss of frame only rises while out of frame.
    a_r10_lof_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> !in_frame);

    // R10: loss of frame only falls while in frame.
    a_r10_lof_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lof) |-> in_frame);

endmodule

bind frm_byte_framer frm_byte_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .alarm_clr (alarm_clr),
    .out_valid (out_valid),
    .out_fp    (out_fp),
    .in_frame  (in_frame),
    .err_alarm (err_alarm),
    .oof_alarm (oof_alarm),
    .lof       (lof)
);

// File: tb/sim_frm_byte_framer.sv
// Bench for frm_byte_framer: builds frames, serialises them with a bit slip,
// repacks them into unaligned bytes with random idle gaps, and checks the
// outputs against values derived from the requirements.
module sim_frm_byte_framer;
    localparam int FLEN = 120;
    localparam int NA1  = 12;
    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] alarm_clr = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_fp;
    logic       in_frame;
    logic       err_alarm;
    logic       oof_alarm;
    logic       lof;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    frm_byte_framer #(.FRAME_LEN(FLEN), .NUM_A1(NA1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .alarm_clr(alarm_clr), .out_valid(out_valid), .out_data(out_data),
        .out_fp(out_fp), .in_frame(in_frame), .err_alarm(err_alarm),
        .oof_alarm(oof_alarm), .lof(lof)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit packer: collects line bits and emits bytes, sometimes with a gap (R11).
    logic [7:0] acc = '0;
    int         nbits = 0;

    task automatic send_byte(input logic [7:0] b);
        if ($urandom_range(0, 3) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
    endtask

    task automatic push_bit(input logic bv);
        acc = {acc[6:0], bv};
        nbits++;
        if (nbits == 8) begin
            send_byte(acc);
            nbits = 0;
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) push_bit(b[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Frame byte j: mode 0 good, 1 last A1 destroyed, 2 payload only.
    // Payload is masked with 0x77 so it never forms a run of four ones.
    function automatic logic [7:0] frame_byte(input int j, input int mode);
        if (mode == 2 || j >= 2 * NA1) return 8'($urandom) & 8'h77;
        if (j < NA1) return (mode == 1 && j == NA1 - 1) ? 8'h00 : A1;
        return A2;
    endfunction

    task automatic send_frames(input int n, input int mode);
        for (int f = 0; f < n; f++)
            for (int j = 0; j < FLEN; j++) push_byte(frame_byte(j, mode));
    endtask

    task automatic clear_pulse(input logic [1:0] v);
        @(negedge clk);
        alarm_clr = v;
        @(negedge clk);
        alarm_clr = '0;
        idle(1);
    endtask

    // Output monitor: pulse spacing, first-A1 position and aligned bytes.
    int         since = 0;
    int         vcnt = 0;
    bit         track = 0;
    bit         have_prev = 0;
    logic [7:0] prev_byte = '0;
    int         fp_total = 0;

    always @(negedge clk) begin
        if (rst_n && !in_frame) begin
            track     <= 0;
            have_prev <= 0;
        end
        if (rst_n && out_valid) begin
            vcnt = vcnt + 1;
            if (out_fp) begin
                fp_total = fp_total + 1;
                chk(out_data == A1, "R6 pulse on A1", out_data, A1);
                chk(prev_byte != A1, "R6 pulse on first A1", prev_byte, 0);
                if (have_prev) chk(vcnt == FLEN, "R6 pulse spacing", vcnt, FLEN);
                vcnt = 0;
                since = 0;
                have_prev <= 1;
                track <= 1;
            end else begin
                since = since + 1;
                if (track && since >= 1 && since <= NA1 - 2)
                    chk(out_data == A1, "R5 A1 bytes R11", out_data, A1);
                if (track && since >= NA1 && since < 2 * NA1)
                    chk(out_data == A2, "R5 A2 bytes R11", out_data, A2);
            end
            prev_byte = out_data;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(out_fp == 0, "R1 out_fp", out_fp, 0);
        chk(in_frame == 0, "R1 in_frame", in_frame, 0);
        chk(err_alarm == 0 && oof_alarm == 0, "R1 alarms", {err_alarm, oof_alarm}, 0);
        chk(lof == 0, "R1 lof", lof, 0);

        // R2: valid passes through with one cycle of latency while out of frame
        @(negedge clk);
        in_data = 8'h11;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1, "R2 valid follows", out_valid, 1);
        @(negedge clk);
        chk(out_valid == 0, "R2 idle follows", out_valid, 0);

        // Bit slip of five before the first byte (R3 offset search)
        for (int i = 0; i < 5; i++) push_bit(1'b0);

        // R10: no pattern at all; LOF boundary at 24 frame periods
        send_frames(22, 2);
        idle(3);
        chk(lof == 0, "R10 lof before 24 periods", lof, 0);
        chk(in_frame == 0, "R4 no frame on payload", in_frame, 0);
        chk(fp_total == 0, "R6 no pulse out of frame", fp_total, 0);
        send_frames(4, 2);
        idle(3);
        chk(lof == 1, "R10 lof after 24 periods", lof, 1);

        // R3/R4: detection then two confirming frames
        send_frames(2, 0);
        idle(3);
        chk(in_frame == 0, "R4 not yet in frame", in_frame, 0);
        send_frames(1, 0);
        idle(3);
        chk(in_frame == 1, "R3 R4 in frame", in_frame, 1);

        // R10: LOF release after 24 in-frame periods
        send_frames(22, 0);
        idle(3);
        chk(lof == 1, "R10 lof held", lof, 1);
        send_frames(4, 0);
        idle(3);
        chk(lof == 0, "R10 lof released", lof, 0);
        chk(fp_total > 20, "R6 pulses seen", fp_total, 20);
        chk(err_alarm == 0, "R7 no errors on good frames", err_alarm, 0);

        // R7: one errored frame
        send_frames(1, 1);
        send_frames(1, 0);
        idle(3);
        chk(err_alarm == 1, "R7 errored frame alarm", err_alarm, 1);
        chk(in_frame == 1, "R7 still in frame", in_frame, 1);
        clear_pulse(2'b01);
        chk(err_alarm == 0, "R9 err cleared", err_alarm, 0);

        // R7: three misses, a good frame, three misses
        send_frames(3, 1);
        send_frames(1, 0);
        send_frames(3, 1);
        send_frames(1, 0);
        idle(3);
        chk(in_frame == 1, "R7 count restarts", in_frame, 1);
        chk(oof_alarm == 0, "R8 no oof alarm yet", oof_alarm, 0);
        chk(err_alarm == 1, "R9 err sticky", err_alarm, 1);

        // R8: four misses end the frame
        send_frames(4, 1);
        idle(3);
        chk(in_frame == 0, "R8 out of frame", in_frame, 0);
        chk(oof_alarm == 1, "R8 oof alarm", oof_alarm, 1);
        clear_pulse(2'b10);
        chk(oof_alarm == 0, "R9 oof cleared", oof_alarm, 0);
        chk(err_alarm == 1, "R9 err untouched by oof clear", err_alarm, 1);

        // R8: new bit offset, relock
        for (int i = 0; i < 3; i++) push_bit(1'b0);
        send_frames(4, 0);
        idle(3);
        chk(in_frame == 1, "R8 relock new offset", in_frame, 1);
        send_frames(2, 0);
        idle(3);
        chk(in_frame == 1, "R5 stays in frame", in_frame, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule